// File: doc/BRIEF.md
# Three-Lane Reed-Solomon Syndrome Calculator

This block sits at the front of a Reed-Solomon (255,239) decoder that works on 8-bit symbols. It evaluates the received polynomial at the sixteen roots alpha^0 through alpha^15 of the code's generator. Arithmetic is in GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1, so alpha^8 reduces to 0x1D. Each clock cycle it accepts a triple of symbols on three lanes. One codeword therefore takes 85 accepted beats. Sixteen accumulators, one per root, fold in every triple by Horner's rule with a step of alpha^(3i). All multiplications are by constants, so each one is a fixed XOR network.

When a codeword's last beat is accepted, the sixteen results go straight into a holding bank. The accumulators then start on the next codeword at once. The holding bank delivers the syndromes one per handshake, lowest root first, to the key-equation stage. A flag beside the stream tells whether the whole set is zero.

Both sides are valid/ready streams. An output beat moves when `out_valid` and `out_ready` are both high. `out_valid` stays high and the data stays stable until the beat moves. An input beat is taken when `in_valid` and `in_ready` are both high. `in_ready` falls only in one case: the next beat would complete a codeword while the holding bank still has syndromes to deliver, other than the final one that moves in that same cycle. While `in_valid` is low, the lanes and `in_first` are ignored.

Top module: `rs_syndrome_3p`

## Requirements
- R1: Lane mapping. Accepted beat k of a codeword (k = 0..84) carries r(254-3k) on `in_sym_a`, r(253-3k) on `in_sym_b` and r(252-3k) on `in_sym_c`. Output beat j is S_j, the sum over all symbols of r_n·alpha^(j·n) in GF(2^8) with field polynomial 0x11D.
- R2: For a valid codeword, all sixteen output beats carry 0x00. `no_error` is 1 on every one of those beats.
- R3: For a corrupted codeword, each output beat equals the syndrome that symbol-serial Horner evaluation gives. `no_error` is 0 on all sixteen beats when any syndrome is nonzero.
- R4: A codeword closes on its 85th accepted beat. `out_valid` stays low before that beat, provided the bank was empty. It is high with `out_index` = 0 in the cycle right after that beat.
- R5: Output beats leave in index order 0..15, one per handshake. While `out_ready` is low, `out_valid`, `out_index`, `out_syndrome` and `no_error` hold steady.
- R6: With `out_ready` held high, codewords can follow each other with no idle beat, and `in_ready` never falls.
- R7: If the bank still holds undelivered syndromes when a codeword's 85th beat is offered, `in_ready` is low. The beat is accepted in the cycle that the bank's last syndrome moves out. Both codewords' syndromes then come out complete and in order.
- R8: Cycles with `in_valid` low change nothing, whatever the lanes and `in_first` carry.
- R9: A beat accepted with `in_first` = 1 opens a new codeword and discards any partly accumulated one. A discarded partial codeword produces no output.
- R10: After synchronous active-high `rst`, `out_valid` is 0 and `in_ready` is 1. The next accepted beat counts as beat 0, even with `in_first` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input triple present |
| in_ready | output | 1 | Triple will be accepted this cycle |
| in_first | input | 1 | Triple is beat 0 of a new codeword |
| in_sym_a | input | 8 | Highest-degree symbol of the triple |
| in_sym_b | input | 8 | Middle symbol of the triple |
| in_sym_c | input | 8 | Lowest-degree symbol of the triple |
| out_valid | output | 1 | Syndrome beat present |
| out_ready | input | 1 | Downstream takes the syndrome beat |
| out_index | output | 4 | Root index j of the syndrome shown |
| out_syndrome | output | 8 | Syndrome value S_j |
| no_error | output | 1 | 1 when all sixteen syndromes of this set are zero |

## Verification
The bench builds the block with its default parameters: sixteen roots and 85 beats per codeword. It therefore runs on genuine (255,239) codewords from a systematic encoder in the bench, and injected error patterns of up to sixteen symbols keep every syndrome set nonzero. The 85-beat frame is much longer than the 16-beat drain, so the only stall case is a receiver that holds off. The bench creates it by holding `out_ready` low through a whole following codeword. Single errors placed on each lane of the first and last beats tie the lane order to closed-form syndrome values.

// File: rtl/rs3p_pkg.sv
`timescale 1ns / 1ps
package rs3p_pkg;
  localparam int unsigned SYM_W = 8;
  // low byte of the field polynomial x^8+x^4+x^3+x^2+1
  localparam logic [SYM_W-1:0] PRIM_TAIL = 8'h1D;

  typedef logic [SYM_W-1:0] sym_t;

  // multiply by alpha (the element x)
  function automatic sym_t gf_xtime(input sym_t a);
    sym_t r;
    r = {a[SYM_W-2:0], 1'b0};
    if (a[SYM_W-1]) r = r ^ PRIM_TAIL;
    return r;
  endfunction

  // general product, used only on constants at elaboration
  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < SYM_W; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  function automatic sym_t gf_alpha_pow(input int unsigned e);
    sym_t p;
    p = sym_t'(1);
    for (int unsigned k = 0; k < e; k++) p = gf_xtime(p);
    return p;
  endfunction
endpackage

// File: rtl/rs3p_gf_cmul.sv
`timescale 1ns / 1ps
// Constant-coefficient GF(2^8) multiplier: a fixed XOR matrix whose column j
// is COEF * alpha^j.
module rs3p_gf_cmul
  import rs3p_pkg::*;
#(
  parameter sym_t COEF = sym_t'(1)
) (
  input  sym_t din,
  output sym_t dout
);
  sym_t term [SYM_W];

  for (genvar j = 0; j < SYM_W; j++) begin : g_col
    localparam sym_t COL = gf_mul(COEF, sym_t'(sym_t'(1) << j));
    assign term[j] = din[j] ? COL : '0;
  end

  always_comb begin
    dout = '0;
    for (int j = 0; j < SYM_W; j++) dout = dout ^ term[j];
  end
endmodule

// File: rtl/rs3p_syn_cell.sv
`timescale 1ns / 1ps
// One root: acc <- acc*a^(3i) + A*a^(2i) + B*a^i + C, acc taken as zero on a fresh beat.
module rs3p_syn_cell
  import rs3p_pkg::*;
#(
  parameter int unsigned ROOT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic fresh,
  input  sym_t lane_a,
  input  sym_t lane_b,
  input  sym_t lane_c,
  output sym_t acc_next
);
  localparam int unsigned ORD = (1 << SYM_W) - 1;
  localparam sym_t K1 = gf_alpha_pow(ROOT % ORD);
  localparam sym_t K2 = gf_alpha_pow((2 * ROOT) % ORD);
  localparam sym_t K3 = gf_alpha_pow((3 * ROOT) % ORD);

  sym_t acc_q;
  sym_t fold_in;
  sym_t fold_out;
  sym_t prod_a;
  sym_t prod_b;

  assign fold_in = fresh ? '0 : acc_q;

  rs3p_gf_cmul #(.COEF(K3)) u_fold   (.din(fold_in), .dout(fold_out));
  rs3p_gf_cmul #(.COEF(K2)) u_lane_a (.din(lane_a),  .dout(prod_a));
  rs3p_gf_cmul #(.COEF(K1)) u_lane_b (.din(lane_b),  .dout(prod_b));

  assign acc_next = fold_out ^ prod_a ^ prod_b ^ lane_c;

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= acc_next;
  end
endmodule

// File: rtl/rs3p_beat_ctrl.sv
`timescale 1ns / 1ps
// Beat counter, codeword boundaries and input back-pressure.
module rs3p_beat_ctrl #(
  parameter int unsigned NCYC = 85
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_first,
  input  logic bank_free,
  output logic in_ready,
  output logic step,
  output logic fresh,
  output logic close
);
  localparam int unsigned CW = $clog2(NCYC);

  logic [CW-1:0] cnt_q;
  logic          at_edge;

  assign at_edge  = (cnt_q == CW'(NCYC - 1));
  // depends on state only, never on the offered beat
  assign in_ready = !at_edge || bank_free;
  assign step     = in_valid && in_ready;
  assign fresh    = in_first || (cnt_q == '0);
  assign close    = step && at_edge && !in_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step) begin
      if (close)      cnt_q <= '0;
      else if (fresh) cnt_q <= CW'(1);
      else            cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/rs3p_syn_bank.sv
`timescale 1ns / 1ps
// Holding bank: parallel load of all syndromes, serial shift-out, zero flag.
module rs3p_syn_bank
  import rs3p_pkg::*;
#(
  parameter int unsigned NSYN = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  sym_t                    load_val [NSYN],
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [$clog2(NSYN)-1:0] out_index,
  output sym_t                    out_syndrome,
  output logic                    no_error,
  output logic                    bank_free
);
  localparam int unsigned IW = $clog2(NSYN);

  sym_t          shreg [NSYN];
  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic          clean_q;
  logic          pop;
  logic          pop_last;
  logic          all_zero;

  assign pop       = busy_q && out_ready;
  assign pop_last  = pop && (idx_q == IW'(NSYN - 1));
  assign bank_free = !busy_q || pop_last;

  always_comb begin
    all_zero = 1'b1;
    for (int k = 0; k < NSYN; k++) begin
      if (load_val[k] != '0) all_zero = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      clean_q <= 1'b0;
      for (int k = 0; k < NSYN; k++) shreg[k] <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      clean_q <= all_zero;
      for (int k = 0; k < NSYN; k++) shreg[k] <= load_val[k];
    end else if (pop) begin
      for (int k = 0; k < NSYN - 1; k++) shreg[k] <= shreg[k+1];
      shreg[NSYN-1] <= '0;
      idx_q <= idx_q + IW'(1);
      if (pop_last) busy_q <= 1'b0;
    end
  end

  assign out_valid    = busy_q;
  assign out_index    = idx_q;
  assign out_syndrome = shreg[0];
  assign no_error     = clean_q;
endmodule

// File: rtl/rs_syndrome_3p.sv
`timescale 1ns / 1ps
module rs_syndrome_3p
  import rs3p_pkg::*;
#(
  parameter int unsigned NSYN = 16,
  parameter int unsigned NCYC = 85
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_first,
  input  logic [SYM_W-1:0]        in_sym_a,
  input  logic [SYM_W-1:0]        in_sym_b,
  input  logic [SYM_W-1:0]        in_sym_c,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [$clog2(NSYN)-1:0] out_index,
  output logic [SYM_W-1:0]        out_syndrome,
  output logic                    no_error
);
  logic step;
  logic fresh;
  logic close;
  logic bank_free;
  sym_t syn_next [NSYN];

  rs3p_beat_ctrl #(.NCYC(NCYC)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_first (in_first),
    .bank_free(bank_free),
    .in_ready (in_ready),
    .step     (step),
    .fresh    (fresh),
    .close    (close)
  );

  for (genvar i = 0; i < NSYN; i++) begin : g_root
    rs3p_syn_cell #(.ROOT(i)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .fresh   (fresh),
      .lane_a  (in_sym_a),
      .lane_b  (in_sym_b),
      .lane_c  (in_sym_c),
      .acc_next(syn_next[i])
    );
  end

  rs3p_syn_bank #(.NSYN(NSYN)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .load        (close),
    .load_val    (syn_next),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_index   (out_index),
    .out_syndrome(out_syndrome),
    .no_error    (no_error),
    .bank_free   (bank_free)
  );
endmodule

// File: rtl/rs_syndrome_3p_chk.sv
`timescale 1ns / 1ps
module rs_syndrome_3p_chk #(
  parameter int unsigned NSYN = 16,
  parameter int unsigned NCYC = 85
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_first,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [$clog2(NSYN)-1:0] out_index,
  input logic [7:0]              out_syndrome,
  input logic                    no_error
);
  localparam int unsigned IW = $clog2(NSYN);
  localparam int unsigned CW = $clog2(NCYC);

  // independent beat count seen at the input port
  logic [CW-1:0] seen_q;
  logic          done_q;
  logic          take;
  logic          closing;

  assign take    = in_valid && in_ready;
  assign closing = take && !in_first && (seen_q == CW'(NCYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= closing;
      if (take) seen_q <= closing ? '0 : (in_first ? CW'(1) : seen_q + CW'(1));
    end
  end

  assert_first_beat_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> done_q && out_index == '0);

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> out_valid && out_index == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_syndrome) && $stable(out_index) && $stable(no_error));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_index != IW'(NSYN - 1) |=> out_valid && out_index == $past(out_index) + IW'(1));

  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid && !(out_ready && out_index == IW'(NSYN - 1)));

  assert_flag_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_syndrome != 8'h00 |-> !no_error);

  assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && in_ready);
endmodule

bind rs_syndrome_3p rs_syndrome_3p_chk #(.NSYN(NSYN), .NCYC(NCYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_first    (in_first),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_index   (out_index),
  .out_syndrome(out_syndrome),
  .no_error    (no_error)
);

// File: tb/rs_syndrome_3p_bench.sv
`timescale 1ns / 1ps
module rs_syndrome_3p_bench;
  localparam int NSYN = 16;
  localparam int NCYC = 85;
  localparam int NSYM = 3 * NCYC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_first = 1'b0;
  logic [7:0] in_sym_a = '0;
  logic [7:0] in_sym_b = '0;
  logic [7:0] in_sym_c = '0;
  logic       out_ready = 1'b1;
  logic       in_ready;
  logic       out_valid;
  logic [3:0] out_index;
  logic [7:0] out_syndrome;
  logic       no_error;

  always #2.5 clk = ~clk;

  rs_syndrome_3p u_rs_syndrome_3p (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
    .in_sym_a(in_sym_a), .in_sym_b(in_sym_b), .in_sym_c(in_sym_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
    .out_syndrome(out_syndrome), .no_error(no_error)
  );

  int checks = 0;
  int errors = 0;
  int stall_cnt = 0;

  logic [7:0] cw    [0:NSYM-1];
  logic [7:0] gp    [0:NSYN];
  logic [7:0] exp_s [0:NSYN-1];

  // output collector (sole writer of these)
  logic [7:0] got_s  [0:511];
  logic [3:0] got_i  [0:511];
  logic       got_ne [0:511];
  int         got_n = 0;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && got_n < 512) begin
      got_s[got_n]  = out_syndrome;
      got_i[got_n]  = out_index;
      got_ne[got_n] = no_error;
      got_n++;
    end
  end

  // reference field arithmetic: carry-less product then reduction by 0x11D
  function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int k = 0; k < 8; k++) if (b[k]) p = p ^ (15'(a) << k);
    for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h11D << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rpow(input int e);
    logic [7:0] p;
    p = 8'h01;
    for (int k = 0; k < e; k++) p = rmul(p, 8'h02);
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic make_gen();
    logic [7:0] t [0:NSYN];
    logic [7:0] r;
    for (int k = 0; k <= NSYN; k++) gp[k] = 8'h00;
    gp[0] = 8'h01;
    for (int i = 0; i < NSYN; i++) begin
      r = rpow(i);
      for (int k = 0; k <= NSYN; k++) t[k] = rmul(gp[k], r) ^ ((k > 0) ? gp[k-1] : 8'h00);
      gp = t;
    end
  endtask

  task automatic make_cw();
    logic [7:0] par [0:NSYN-1];
    logic [7:0] fb;
    for (int k = 0; k < NSYN; k++) par[k] = 8'h00;
    for (int j = NSYM - 1; j >= NSYN; j--) begin
      cw[j] = 8'($urandom);
      fb = cw[j] ^ par[NSYN-1];
      for (int k = NSYN - 1; k > 0; k--) par[k] = par[k-1] ^ rmul(fb, gp[k]);
      par[0] = rmul(fb, gp[0]);
    end
    for (int k = 0; k < NSYN; k++) cw[k] = par[k];
  endtask

  task automatic inject(input int nerr);
    bit used [0:NSYM-1];
    int p;
    for (int k = 0; k < NSYM; k++) used[k] = 1'b0;
    for (int e = 0; e < nerr; e++) begin
      p = int'($urandom % NSYM);
      while (used[p]) p = int'($urandom % NSYM);
      used[p] = 1'b1;
      cw[p] = cw[p] ^ 8'($urandom % 255 + 1);
    end
  endtask

  task automatic calc_ref();
    logic [7:0] s;
    logic [7:0] a;
    for (int i = 0; i < NSYN; i++) begin
      s = 8'h00;
      a = rpow(i);
      for (int j = NSYM - 1; j >= 0; j--) s = rmul(s, a) ^ cw[j];
      exp_s[i] = s;
    end
  endtask

  // called at posedge+1; returns at posedge+1 after the beat is taken
  task automatic drive_beat(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic first);
    in_valid = 1'b1; in_first = first;
    in_sym_a = a; in_sym_b = b; in_sym_c = c;
    @(negedge clk);
    while (!in_ready) begin stall_cnt++; @(negedge clk); end
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic idle_junk(input int n);
    in_valid = 1'b0;
    in_first = 1'($urandom);
    in_sym_a = 8'($urandom); in_sym_b = 8'($urandom); in_sym_c = 8'($urandom);
    repeat (n) begin @(posedge clk); #1; end
    in_first = 1'b0;
  endtask

  task automatic send_beats(input int from, input int upto, input bit mark_first, input bit gaps);
    for (int k = from; k < upto; k++) begin
      if (gaps && ($urandom % 3 == 0)) idle_junk(int'($urandom % 4) + 1);
      drive_beat(cw[NSYM-1-3*k], cw[NSYM-2-3*k], cw[NSYM-3-3*k], mark_first && k == 0);
    end
  endtask

  task automatic check_out(input int base, input logic [7:0] e [0:NSYN-1], input string tag);
    bit clean;
    clean = 1'b1;
    for (int k = 0; k < NSYN; k++) if (e[k] != 8'h00) clean = 1'b0;
    while (got_n < base + NSYN) @(negedge clk);
    for (int k = 0; k < NSYN; k++) begin
      chk(got_s[base+k] == e[k], tag, $sformatf("syndrome %0d", k), got_s[base+k], e[k]);
      chk(got_i[base+k] == 4'(k), "R5", "index order", got_i[base+k], k);
      chk(got_ne[base+k] == clean, clean ? "R2" : "R3", "no_error", got_ne[base+k], clean);
    end
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
    make_cw(); inject(2); calc_ref();
    begin
      int base = got_n;
      send_beats(0, NCYC, 1'b0, 1'b0);
      check_out(base, exp_s, "R10");
    end
  endtask

  task automatic t_clean();
    for (int n = 0; n < 2; n++) begin
      int base;
      make_cw(); calc_ref();
      base = got_n;
      send_beats(0, NCYC, 1'b1, 1'b0);
      check_out(base, exp_s, "R2");
    end
  endtask

  task automatic t_errors();
    int counts [0:3] = '{1, 4, 8, 16};
    for (int n = 0; n < 4; n++) begin
      int base;
      make_cw(); inject(counts[n]); calc_ref();
      base = got_n;
      send_beats(0, NCYC, 1'b1, 1'b0);
      check_out(base, exp_s, "R3");
    end
  endtask

  // single error on a known lane: closed form S_j = e * alpha^(j*pos)
  task automatic t_lane(input int pos, input logic [7:0] ev);
    int base;
    make_cw();
    cw[pos] = cw[pos] ^ ev;
    for (int i = 0; i < NSYN; i++) exp_s[i] = rmul(ev, rpow((i * pos) % 255));
    base = got_n;
    send_beats(0, NCYC, 1'b1, 1'b0);
    check_out(base, exp_s, "R1");
  endtask

  task automatic t_latency();
    int base;
    make_cw(); inject(3); calc_ref();
    base = got_n;
    send_beats(0, NCYC - 1, 1'b1, 1'b0);
    idle_junk(3);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", "out_valid before last beat", out_valid, 0);
    @(posedge clk); #1;
    send_beats(NCYC - 1, NCYC, 1'b0, 1'b0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4", "out_valid one cycle after last beat", out_valid, 1);
    chk(out_index == 4'd0, "R4", "first out_index", out_index, 0);
    @(posedge clk); #1;
    check_out(base, exp_s, "R4");
  endtask

  task automatic t_back_to_back();
    logic [7:0] sav [0:NSYN-1];
    int base;
    base = got_n;
    stall_cnt = 0;
    make_cw(); inject(3); calc_ref(); sav = exp_s;
    send_beats(0, NCYC, 1'b1, 1'b0);
    make_cw(); calc_ref();
    send_beats(0, NCYC, 1'b1, 1'b0);
    chk(stall_cnt == 0, "R6", "stall cycles back-to-back", stall_cnt, 0);
    check_out(base, sav, "R6");
    check_out(base + NSYN, exp_s, "R6");
  endtask

  task automatic t_gaps();
    int base;
    make_cw(); inject(5); calc_ref();
    base = got_n;
    send_beats(0, NCYC, 1'b1, 1'b1);
    check_out(base, exp_s, "R8");
  endtask

  task automatic t_backpressure();
    logic [7:0] sav [0:NSYN-1];
    int base;
    base = got_n;
    out_ready = 1'b0;
    make_cw(); inject(2); calc_ref(); sav = exp_s;
    send_beats(0, NCYC, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(out_valid == 1'b1, "R5", "out_valid held", out_valid, 1);
    chk(out_syndrome == sav[0], "R5", "held syndrome", out_syndrome, sav[0]);
    @(negedge clk);
    chk(out_syndrome == sav[0], "R5", "held syndrome later", out_syndrome, sav[0]);
    chk(out_index == 4'd0, "R5", "held index", out_index, 0);
    @(posedge clk); #1;
    make_cw(); calc_ref();
    stall_cnt = 0;
    send_beats(0, NCYC - 1, 1'b1, 1'b0);
    chk(stall_cnt == 0, "R7", "stalls before closing beat", stall_cnt, 0);
    in_valid = 1'b1; in_first = 1'b0;
    in_sym_a = cw[2]; in_sym_b = cw[1]; in_sym_c = cw[0];
    repeat (4) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R7", "in_ready while bank full", in_ready, 0);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check_out(base, sav, "R7");
    check_out(base + NSYN, exp_s, "R7");
  endtask

  task automatic t_restart();
    int base;
    base = got_n;
    for (int k = 0; k < 30; k++) drive_beat(8'($urandom), 8'($urandom), 8'($urandom), k == 0);
    make_cw(); inject(2); calc_ref();
    send_beats(0, NCYC, 1'b1, 1'b0);
    check_out(base, exp_s, "R9");
  endtask

  initial begin
    make_gen();
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_clean();
    t_errors();
    t_lane(254, 8'h5A);
    t_lane(253, 8'h33);
    t_lane(0, 8'hC3);
    t_latency();
    t_back_to_back();
    t_gaps();
    t_backpressure();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog: run active after %0d cycles, expected completion", 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule